// File: doc/BRIEF.md
# Bounded Range Check Unit

This unit decides whether a register operand falls inside an inclusive pair of limits, a lower and an upper one, and reports the result through a five-bit condition flag vector. The operand may be a byte, a half-word (word) or a full word (long). Before any comparison, the limits and, for data-class registers, the operand are widened to the full datapath width by sign extension. Address-class registers are always compared at full width without any extension.

The check rests on two unsigned differences: the operand minus the lower limit, and the upper limit minus the lower limit. When the first difference exceeds the second, the operand is out of range and the carry flag is raised. The zero flag reports equality with either limit. Extend, negative and overflow are passed through from the incoming flags. A result is captured on an input strobe and appears one cycle later together with an output strobe.

The flag vector uses these bit positions: bit 4 extend, bit 3 negative, bit 2 zero, bit 1 overflow, bit 0 carry.

Top module: `bound_check`

## Requirements
- R1: While rst_ni is low, and after its release until the first strobe, valid_o is 0 and flags_o is 5'b00000.
- R2: valid_o is high in the cycle after one in which valid_i is high, and low in the cycle after one in which valid_i is low.
- R3: flags_o keeps its value in every cycle that follows a cycle with valid_i low, whatever the other inputs do.
- R4: Bits 4 (extend), 3 (negative) and 1 (overflow) of flags_o equal the same bits of flags_i captured with the strobe.
- R5: Bit 2 (zero) of flags_o is 1 exactly when the extended operand equals the extended lower limit or the extended upper limit.
- R6: Bit 0 (carry) of flags_o is 1 exactly when (operand − lower), taken as an unsigned 32-bit difference, is greater than (upper − lower), also taken as an unsigned 32-bit difference. The incoming zero and carry bits have no effect.
- R7: With size code 2'b00 (byte), both limits are sign-extended from bit 7. With size code 2'b01 (word), both limits are sign-extended from bit 15. Bits above the operand size are ignored.
- R8: When is_addr_i is 0, the operand is sign-extended from the operation size. When is_addr_i is 1, all 32 bits of the operand are used unchanged.
- R9: Size code 2'b11 behaves exactly as size code 2'b10.
- R10: With size code 2'b10 (long), both limits and the operand are used as full 32-bit values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Capture strobe for one check |
| val_i | input | 32 | Register operand |
| is_addr_i | input | 1 | 1: address-class register, 0: data-class register |
| lo_i | input | 32 | Lower limit |
| hi_i | input | 32 | Upper limit |
| size_i | input | 2 | Operation size: 00 byte, 01 word, 10 long, 11 long |
| flags_i | input | 5 | Incoming condition flags |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| flags_o | output | 5 | Updated condition flags |

## Verification
The bench builds the unit with its default widths: a 32-bit datapath, an 8-bit byte and a 16-bit word. This places the sign-extension boundaries at bits 7 and 15, where hand-picked limits with unrelated upper bits show that those bits are ignored. It also makes address-class operands that would fall in range after truncation land out of range. The 32-bit width lets the wrapping unsigned differences be exercised at the top of the range, with limits at 32'h8000_0000, and with inverted limit pairs in the random stream.

// File: rtl/bchk_pkg.sv
package bchk_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_FULL = 2'b10,
    SZ_ALT  = 2'b11
  } size_e;

  localparam int unsigned FLG_W = 5;
  localparam int unsigned FLG_C = 0;
  localparam int unsigned FLG_V = 1;
  localparam int unsigned FLG_Z = 2;
  localparam int unsigned FLG_N = 3;
  localparam int unsigned FLG_X = 4;

  // operand slots fed through the extender bank
  localparam int unsigned OP_VAL = 0;
  localparam int unsigned OP_LO  = 1;
  localparam int unsigned OP_HI  = 2;
  localparam int unsigned OP_N   = 3;
endpackage

// File: rtl/bchk_extend.sv
module bchk_extend
  import bchk_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned HALF_W = 16
) (
  input  logic [DATA_W-1:0] op_i,
  input  logic [1:0]        size_i,
  input  logic              bypass_i,
  output logic [DATA_W-1:0] op_o
);
  localparam int unsigned BYTE_PAD = DATA_W - BYTE_W;
  localparam int unsigned HALF_PAD = DATA_W - HALF_W;

  logic [DATA_W-1:0] byte_ext;
  logic [DATA_W-1:0] half_ext;
  size_e             sz;

  assign sz       = size_e'(size_i);
  assign byte_ext = {{BYTE_PAD{op_i[BYTE_W-1]}}, op_i[BYTE_W-1:0]};
  assign half_ext = {{HALF_PAD{op_i[HALF_W-1]}}, op_i[HALF_W-1:0]};

  always_comb begin
    if (bypass_i) begin
      op_o = op_i;
    end else begin
      unique case (sz)
        SZ_BYTE: op_o = byte_ext;
        SZ_HALF: op_o = half_ext;
        default: op_o = op_i;  // full and alternate full
      endcase
    end
  end
endmodule

// File: rtl/bchk_compare.sv
module bchk_compare #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  output logic              eq_o,
  output logic              out_o
);
  logic [DATA_W-1:0] off_val;
  logic [DATA_W-1:0] span;

  // modular differences: inverted pairs wrap consistently
  assign off_val = val_i - lo_i;
  assign span    = hi_i - lo_i;
  assign eq_o    = (val_i == lo_i) || (val_i == hi_i);
  assign out_o   = off_val > span;
endmodule

// File: rtl/bound_check.sv
module bound_check
  import bchk_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic              is_addr_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [1:0]        size_i,
  input  logic [FLG_W-1:0]  flags_i,
  output logic              valid_o,
  output logic [FLG_W-1:0]  flags_o
);
  logic [DATA_W-1:0] raw_op [OP_N];
  logic [DATA_W-1:0] ext_op [OP_N];
  logic              bypass [OP_N];
  logic              hit_eq;
  logic              hit_out;
  logic [FLG_W-1:0]  flags_d;

  assign raw_op[OP_VAL] = val_i;
  assign raw_op[OP_LO]  = lo_i;
  assign raw_op[OP_HI]  = hi_i;
  assign bypass[OP_VAL] = is_addr_i;
  assign bypass[OP_LO]  = 1'b0;
  assign bypass[OP_HI]  = 1'b0;

  for (genvar g = 0; g < OP_N; g++) begin : g_ext
    bchk_extend #(
      .DATA_W(DATA_W),
      .BYTE_W(BYTE_W),
      .HALF_W(HALF_W)
    ) u_ext (
      .op_i    (raw_op[g]),
      .size_i  (size_i),
      .bypass_i(bypass[g]),
      .op_o    (ext_op[g])
    );
  end

  bchk_compare #(
    .DATA_W(DATA_W)
  ) u_cmp (
    .val_i(ext_op[OP_VAL]),
    .lo_i (ext_op[OP_LO]),
    .hi_i (ext_op[OP_HI]),
    .eq_o (hit_eq),
    .out_o(hit_out)
  );

  always_comb begin
    flags_d        = flags_i;
    flags_d[FLG_Z] = hit_eq;
    flags_d[FLG_C] = hit_out;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      flags_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) flags_o <= flags_d;
    end
  end
endmodule

// File: rtl/bchk_checker.sv
module bchk_checker
  import bchk_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] val_i,
  input logic              is_addr_i,
  input logic [DATA_W-1:0] lo_i,
  input logic [DATA_W-1:0] hi_i,
  input logic [1:0]        size_i,
  input logic [FLG_W-1:0]  flags_i,
  input logic              valid_o,
  input logic [FLG_W-1:0]  flags_o
);
  logic full_sz;
  assign full_sz = size_i[1];

  AST_STROBE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |=> valid_o); // R2
  AST_STROBE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> !valid_o); // R2
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> $stable(flags_o)); // R3
  AST_PASS_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (flags_o[FLG_X] == $past(flags_i[FLG_X])) && (flags_o[FLG_N] == $past(flags_i[FLG_N]))
             && (flags_o[FLG_V] == $past(flags_i[FLG_V]))); // R4
  AST_EQ_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && full_sz && (val_i == lo_i) |=> flags_o[FLG_Z]); // R5
  AST_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && full_sz && (lo_i <= hi_i) && (val_i >= lo_i) && (val_i <= hi_i) |=> !flags_o[FLG_C]); // R6
  AST_ABOVE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && full_sz && (lo_i <= hi_i) && (val_i > hi_i) |=> flags_o[FLG_C]); // R6
  AST_RESET_IDLE: assert property (@(posedge clk_i) !rst_ni |-> !valid_o && (flags_o == '0)); // R1
endmodule

bind bound_check bchk_checker #(.DATA_W(DATA_W)) u_bchk_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .val_i    (val_i),
  .is_addr_i(is_addr_i),
  .lo_i     (lo_i),
  .hi_i     (hi_i),
  .size_i   (size_i),
  .flags_i  (flags_i),
  .valid_o  (valid_o),
  .flags_o  (flags_o)
);

// File: tb/bound_check_test.sv
module bound_check_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] val = '0, lo = '0, hi = '0;
  logic        is_addr = 1'b0;
  logic [1:0]  size = '0;
  logic [4:0]  flags_in = '0;
  logic        valid_o;
  logic [4:0]  flags_o;
  logic        exp_valid = 1'b0;
  logic [4:0]  exp_flags = '0;
  int          n_run = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  bound_check uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .val_i(val), .is_addr_i(is_addr),
    .lo_i(lo), .hi_i(hi), .size_i(size), .flags_i(flags_in),
    .valid_o(valid_o), .flags_o(flags_o)
  );

  function automatic longint widen(input logic [31:0] x, input logic [1:0] sz, input bit keep);
    longint r;
    if (keep || sz[1]) r = longint'(x);
    else if (sz == 2'b00) r = longint'($signed(x[7:0]));
    else r = longint'($signed(x[15:0]));
    return r & 64'hFFFF_FFFF;
  endfunction

  function automatic logic [4:0] model(input logic [31:0] v, input bit a, input logic [31:0] l,
                                       input logic [31:0] h, input logic [1:0] sz, input logic [4:0] f);
    longint ev = widen(v, sz, a);
    longint el = widen(l, sz, 1'b0);
    longint eh = widen(h, sz, 1'b0);
    longint dv = (ev - el) & 64'hFFFF_FFFF;
    longint dh = (eh - el) & 64'hFFFF_FFFF;
    bit z = (ev == el) || (ev == eh);
    bit c = dv > dh;
    return {f[4], f[3], z, f[1], c};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid <= 1'b0;
      exp_flags <= '0;
    end else begin
      exp_valid <= valid;
      if (valid) exp_flags <= model(val, is_addr, lo, hi, size, flags_in);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every-clock comparison against the reference model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 strobe", 32'(valid_o), 32'(exp_valid));
      check("R3 flags vs model", 32'(flags_o), 32'(exp_flags));
    end
  end

  task automatic apply(input logic [31:0] v, input bit a, input logic [31:0] l, input logic [31:0] h,
                       input logic [1:0] sz, input logic [4:0] f);
    @(negedge clk);
    val = v; is_addr = a; lo = l; hi = h; size = sz; flags_in = f; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(valid_o), 0);
    check("R1 reset flags", 32'(flags_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", 32'(flags_o), 0);

    // byte data: -11 inside [-16,16], upper bits ignored
    apply(32'h1234_00F5, 1'b0, 32'hABCD_00F0, 32'h5555_5510, 2'b00, 5'b00101);
    check("R7 R8 byte data in range", 32'(flags_o), 32'(5'b00000));
    // address class uses the full value: out of range
    apply(32'h1234_00F5, 1'b1, 32'hABCD_00F0, 32'h5555_5510, 2'b00, 5'b00000);
    check("R8 address full width", 32'(flags_o), 32'(5'b00001));
    // word: equal to lower
    apply(32'h0000_8000, 1'b0, 32'h1111_8000, 32'h2222_7FFF, 2'b01, 5'b00000);
    check("R5 word equals lower", 32'(flags_o), 32'(5'b00100));
    apply(32'hFFFF_7FFF, 1'b0, 32'h0000_8000, 32'h0000_7FFF, 2'b01, 5'b00000);
    check("R5 word equals upper", 32'(flags_o), 32'(5'b00100));
    // long above
    apply(32'd201, 1'b0, 32'd100, 32'd200, 2'b10, 5'b11010);
    check("R6 R4 long above upper", 32'(flags_o), 32'(5'b11011));
    apply(32'h8000_0005, 1'b0, 32'h8000_0000, 32'h8000_0010, 2'b10, 5'b00000);
    check("R10 long high values", 32'(flags_o), 32'(5'b00000));
    apply(32'h0000_0105, 1'b0, 32'h0000_0010, 32'h0000_01FF, 2'b11, 5'b01000);
    check("R9 code 11 as long", 32'(flags_o), 32'(5'b01000));
    apply(32'h0000_0105, 1'b0, 32'h0000_0010, 32'h0000_01FF, 2'b00, 5'b01000);
    check("R7 same pair as byte", 32'(flags_o), 32'(5'b01001));

    // hold: inputs change without a strobe
    val = 32'd7; lo = 32'd0; hi = 32'd1; flags_in = 5'b11111; size = 2'b10;
    repeat (3) @(negedge clk);
    check("R3 hold without strobe", 32'(flags_o), 32'(5'b01001));
    check("R2 idle strobe", 32'(valid_o), 0);

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      val = $urandom; lo = $urandom; hi = $urandom;
      if (i % 4 == 0) begin lo = lo & 32'h0000_00FF; hi = lo + ($urandom & 32'h1F); val = lo + ($urandom & 32'h3F); end
      if (i % 7 == 0) val = hi;
      is_addr = 1'($urandom); size = 2'($urandom); flags_in = 5'($urandom);
      valid = 1'($urandom);
    end
    @(negedge clk);
    valid = 1'b0;
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule